// File: doc/BRIEF.md
# Message-Triggered ROM Fetch Controller

This block drives the stand-alone playback path of a speech engine. A host selects one of up to 256 messages by placing an 8-bit number on a code input and raising a start strobe while chip select is low. The block latches the number and pulls an active-low busy output low. It then reads the message's start address from a directory held in an external byte-wide ROM. After that it walks the message body byte by byte and hands each byte to a downstream decoder over a valid/ready stream.

The external ROM is reached through a multiplexed bus with a 17-bit address. The low 9 address bits leave on a dedicated port. The high 8 bits leave on the shared byte port and are captured by an external latch on the falling edge of an address strobe. The data byte then comes back on the same pins while an active-low enable marks the read window. A separate flag stays high while the two directory bytes are being read. All timing counts are in system clocks (640 kHz in the target system).

A message body is a sequence of records. Each record is a command byte N (1 to 255) followed by N data bytes. A zero command byte ends the message.

Top module: `msg_fetch_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy_n is 1, aen_n is 1, and dir_flag, ale, rom_hi_oe and m_valid are all 0.
- R2: A rising edge of start, sampled while sel_n is 0 and the block is idle, latches msg_code and drives busy_n to 0 on the next clock edge. The same edge with sel_n at 1 changes nothing.
- R3: While busy_n is 0, further start edges are ignored. The message being played and its byte stream do not change, and no new message begins after the current one ends.
- R4: Each ROM access presents a 17-bit address. Bits 8..0 appear on rom_addr_lo for the whole access. Bits 16..9 appear on rom_hi_out while rom_hi_oe is 1.
- R5: Each access runs in a fixed order. First, rom_hi_oe is high for 4 clocks. ale is high for the first 2 of those clocks, so the high byte stays valid 2 clocks before and 2 clocks after ale falls. Next, aen_n is low for exactly 9 clocks, and rom_data_in is sampled in the last of them. rom_hi_oe is never 1 while aen_n is 0.
- R6: Consecutive accesses begin at least 24 clocks apart.
- R7: For message n, the first two accesses read DIR_BASE+2n and then DIR_BASE+2n+1. dir_flag is 1 during exactly those two accesses.
- R8: If the directory bytes are b0 (first) and b1 (second), the start address is {b1[0], b1[7:1], b0, 1'b0}. Accesses then continue at consecutive addresses, wrapping at 17 bits.
- R9: In the body, a command byte N other than 0 is followed by N data bytes of any value, including 0. A 0 command byte is not streamed; busy_n returns to 1 and the block waits for a new start.
- R10: Every command and data byte is offered on m_data with m_valid in fetch order. It is held unchanged until m_ready is 1, and no ROM access runs while a byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low, qualifies start |
| start | input | 1 | Start strobe, acts on its rising edge |
| msg_code | input | 8 | Message number |
| busy_n | output | 1 | Low while a message is being played |
| dir_flag | output | 1 | High during the two directory reads |
| rom_addr_lo | output | 9 | Low ROM address bits 8..0 |
| rom_hi_out | output | 8 | High ROM address bits 16..9 on the shared port |
| rom_hi_oe | output | 1 | Drive enable of the shared port |
| rom_data_in | input | 8 | Data read back on the shared port |
| ale | output | 1 | Strobe; external latch captures high byte on its falling edge |
| aen_n | output | 1 | Active-low ROM read window |
| m_valid | output | 1 | Stream byte valid |
| m_data | output | 8 | Stream byte |
| m_ready | input | 1 | Stream consumer ready |

## Verification
Assertions check the bus phase rules on every cycle: the 2-clock strobe, the high-byte hold after its falling edge, the 9-clock read window and the absence of port contention. They also check that a held stream byte stays stable, that no access runs while it is held, that the latched code is frozen while busy, and that dir_flag only appears while busy. Only the bench scenarios can show the rest: that the right directory entry is read, that the decoded start address and address increments are right, that record lengths are parsed so only the zero command ends a message, that 24-clock access spacing holds, and that ignored starts leave the stream unchanged.

// File: rtl/msg_fetch_pkg.sv
package msg_fetch_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_DIR_LO,
    FS_DIR_HI,
    FS_CMD,
    FS_DATA,
    FS_HOLD
  } fetch_st_t;
endpackage

// File: rtl/msg_start_catch.sv
module msg_start_catch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sel_n,
  input  logic          armed,
  input  logic [DW-1:0] code_in,
  output logic          fire,
  output logic [DW-1:0] code_q
);
  logic start_q;

  assign fire = start & ~start_q & ~sel_n & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      code_q  <= '0;
    end else begin
      start_q <= start;
      if (fire) code_q <= code_in;
    end
  end

  // R3: code cannot move while a message is in progress
  a_r3_code_frozen: assert property (@(posedge clk) disable iff (rst)
    (!armed && $past(!armed)) |-> $stable(code_q));
endmodule

// File: rtl/msg_rom_access.sv
module msg_rom_access #(
  parameter int AW     = 17,
  parameter int LOW_W  = 9,
  parameter int DW     = 8,
  parameter int T_ALE  = 2,
  parameter int T_HOLD = 2,
  parameter int T_AEN  = 9,
  parameter int T_CYC  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    bus_in,
  output logic             active,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic [LOW_W-1:0] addr_lo,
  output logic [AW-LOW_W-1:0] hi_out,
  output logic             hi_oe,
  output logic             ale,
  output logic             aen_n
);
  localparam int CW = $clog2(T_CYC + 1);
  localparam int RW = $clog2(T_AEN + 2);
  localparam logic [CW-1:0] ALE_LAST  = CW'(T_ALE - 1);
  localparam logic [CW-1:0] OE_LAST   = CW'(T_ALE + T_HOLD - 1);
  localparam logic [CW-1:0] AEN_FIRST = CW'(T_ALE + T_HOLD);
  localparam logic [CW-1:0] AEN_LAST  = CW'(T_ALE + T_HOLD + T_AEN - 1);
  localparam logic [CW-1:0] PH_LAST   = CW'(T_CYC - 1);
  localparam logic [RW-1:0] AEN_LEN   = RW'(T_AEN);

  logic [CW-1:0] cnt, p_nxt;
  logic [AW-1:0] addr_q, a_nxt;
  logic          load;

  always_comb begin
    p_nxt = active ? cnt + CW'(1) : '0;
    a_nxt = active ? addr_q : addr;
    load  = active ? (cnt != PH_LAST) : go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      addr_q  <= '0;
      rdata   <= '0;
      addr_lo <= '0;
      hi_out  <= '0;
      hi_oe   <= 1'b0;
      ale     <= 1'b0;
      aen_n   <= 1'b1;
    end else begin
      done <= active && (cnt == PH_LAST);
      if (active && cnt == AEN_LAST) rdata <= bus_in;
      if (load) begin
        active  <= 1'b1;
        cnt     <= p_nxt;
        addr_q  <= a_nxt;
        addr_lo <= a_nxt[LOW_W-1:0];
        hi_oe   <= (p_nxt <= OE_LAST);
        hi_out  <= (p_nxt <= OE_LAST) ? a_nxt[AW-1:LOW_W] : '0;
        ale     <= (p_nxt <= ALE_LAST);
        aen_n   <= !((p_nxt >= AEN_FIRST) && (p_nxt <= AEN_LAST));
      end else begin
        active <= 1'b0;
        cnt    <= '0;
        hi_oe  <= 1'b0;
        hi_out <= '0;
        ale    <= 1'b0;
        aen_n  <= 1'b1;
      end
    end
  end

  logic [RW-1:0] aen_run;
  always_ff @(posedge clk) begin
    if (rst) aen_run <= '0;
    else     aen_run <= aen_n ? '0 : aen_run + RW'(1);
  end

  // R5: strobe lasts two clocks
  a_r5_ale_two: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale ##1 !ale);
  // R5: high byte held two clocks past the strobe's falling edge
  a_r5_hi_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> hi_oe ##1 hi_oe ##1 !hi_oe);
  // R5: shared port never driven inside the read window
  a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
    !aen_n |-> !hi_oe);
  // R5: read window width
  a_r5_aen_width: assert property (@(posedge clk) disable iff (rst)
    $rose(aen_n) |-> (aen_run == AEN_LEN));
  // R4: high byte steady while driven
  a_r4_hi_stable: assert property (@(posedge clk) disable iff (rst)
    (hi_oe && $past(hi_oe)) |-> $stable(hi_out));
endmodule

// File: rtl/msg_fetch_ctrl.sv
module msg_fetch_ctrl #(
  parameter int             AW       = 17,
  parameter int             LOW_W    = 9,
  parameter int             DW       = 8,
  parameter logic [16:0]    DIR_BASE = 17'h00000,
  parameter int             T_ALE    = 2,
  parameter int             T_HOLD   = 2,
  parameter int             T_AEN    = 9,
  parameter int             T_CYC    = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             start,
  input  logic [DW-1:0]    msg_code,
  output logic             busy_n,
  output logic             dir_flag,
  output logic [LOW_W-1:0] rom_addr_lo,
  output logic [DW-1:0]    rom_hi_out,
  output logic             rom_hi_oe,
  input  logic [DW-1:0]    rom_data_in,
  output logic             ale,
  output logic             aen_n,
  output logic             m_valid,
  output logic [DW-1:0]    m_data,
  input  logic             m_ready
);
  import msg_fetch_pkg::*;

  fetch_st_t     st, ret;
  logic          fire, go, issued, acc_busy, acc_done;
  logic [DW-1:0] code_q, rd, lo_b, remain;
  logic [AW-1:0] ptr, dir_addr, acc_addr;

  msg_start_catch #(.DW(DW)) u_start (
    .clk(clk), .rst(rst), .start(start), .sel_n(sel_n),
    .armed(st == FS_IDLE), .code_in(msg_code),
    .fire(fire), .code_q(code_q)
  );

  always_comb begin
    dir_addr = AW'(DIR_BASE) + AW'({code_q, 1'b0});
    case (st)
      FS_DIR_LO: acc_addr = dir_addr;
      FS_DIR_HI: acc_addr = dir_addr + AW'(1);
      default:   acc_addr = ptr;
    endcase
  end

  msg_rom_access #(
    .AW(AW), .LOW_W(LOW_W), .DW(DW),
    .T_ALE(T_ALE), .T_HOLD(T_HOLD), .T_AEN(T_AEN), .T_CYC(T_CYC)
  ) u_acc (
    .clk(clk), .rst(rst), .go(go), .addr(acc_addr), .bus_in(rom_data_in),
    .active(acc_busy), .done(acc_done), .rdata(rd),
    .addr_lo(rom_addr_lo), .hi_out(rom_hi_out), .hi_oe(rom_hi_oe),
    .ale(ale), .aen_n(aen_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      ret      <= FS_CMD;
      busy_n   <= 1'b1;
      dir_flag <= 1'b0;
      go       <= 1'b0;
      issued   <= 1'b0;
      ptr      <= '0;
      lo_b     <= '0;
      remain   <= '0;
      m_valid  <= 1'b0;
      m_data   <= '0;
    end else begin
      go <= 1'b0;
      case (st)
        FS_IDLE: if (fire) begin
          st       <= FS_DIR_LO;
          busy_n   <= 1'b0;
          dir_flag <= 1'b1;
        end
        FS_HOLD: if (m_ready) begin
          m_valid <= 1'b0;
          st      <= ret;
        end
        default: begin
          if (!issued && !acc_busy && !acc_done) begin
            go     <= 1'b1;
            issued <= 1'b1;
          end
          if (acc_done) begin
            issued <= 1'b0;
            case (st)
              FS_DIR_LO: begin
                lo_b <= rd;
                st   <= FS_DIR_HI;
              end
              FS_DIR_HI: begin
                ptr      <= {rd[0], rd[DW-1:1], lo_b, 1'b0};
                dir_flag <= 1'b0;
                st       <= FS_CMD;
              end
              FS_CMD: begin
                if (rd == '0) begin
                  busy_n <= 1'b1;
                  st     <= FS_IDLE;
                end else begin
                  m_data  <= rd;
                  m_valid <= 1'b1;
                  remain  <= rd;
                  ptr     <= ptr + AW'(1);
                  ret     <= FS_DATA;
                  st      <= FS_HOLD;
                end
              end
              default: begin
                m_data  <= rd;
                m_valid <= 1'b1;
                remain  <= remain - DW'(1);
                ptr     <= ptr + AW'(1);
                ret     <= (remain == DW'(1)) ? FS_CMD : FS_DATA;
                st      <= FS_HOLD;
              end
            endcase
          end
        end
      endcase
    end
  end

  // R10: a byte not taken stays put
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  // R10: no ROM traffic while a byte waits
  a_r10_no_fetch_held: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (aen_n && !rom_hi_oe));
  // R9: nothing streams when not busy
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    busy_n |-> !m_valid);
  // R7: directory flag only inside a message
  a_r7_dir_in_busy: assert property (@(posedge clk) disable iff (rst)
    dir_flag |-> !busy_n);
endmodule

// File: tb/sim_msg_fetch_ctrl.sv
module sim_msg_fetch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_CYC = 24;
  localparam int N_MSG = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, start = 1'b0, m_ready = 1'b0;
  logic [7:0] msg_code = 8'h00, rom_data_in = 8'h00;
  logic busy_n, dir_flag, rom_hi_oe, ale, aen_n, m_valid;
  logic [8:0] rom_addr_lo;
  logic [7:0] rom_hi_out, m_data, hi_q = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_fetch_ctrl u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .start(start), .msg_code(msg_code),
    .busy_n(busy_n), .dir_flag(dir_flag), .rom_addr_lo(rom_addr_lo),
    .rom_hi_out(rom_hi_out), .rom_hi_oe(rom_hi_oe), .rom_data_in(rom_data_in),
    .ale(ale), .aen_n(aen_n), .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] rom [int];
  function automatic logic [7:0] rom_rd(input int a);
    return rom.exists(a) ? rom[a] : 8'hFF;
  endfunction

  // external ROM and high-address latch
  always @(negedge ale) hi_q <= rom_hi_out;
  always @(negedge clk) rom_data_in <= aen_n ? 8'h00 : rom_rd(int'({hi_q, rom_addr_lo}));

  // bus monitor
  int acc_addr_q[$];
  bit acc_dir_q[$];
  int cyc = 0, ale_run = 0, oe_run = 0, aen_run = 0, last_start = -1;
  bit aen_prev = 1'b1, oe_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (rom_hi_oe && !oe_prev) begin
        if (last_start >= 0) chk(cyc - last_start >= T_CYC, "R6 access spacing", cyc - last_start, T_CYC);
        last_start = cyc;
      end
      if (ale) ale_run++;
      else if (ale_run != 0) begin
        chk(ale_run == 2, "R5 ale width", ale_run, 2);
        chk(rom_hi_oe == 1'b1, "R5 hi hold after ale fall", rom_hi_oe, 1);
        ale_run = 0;
      end
      if (rom_hi_oe) oe_run++;
      else if (oe_run != 0) begin
        chk(oe_run == 4, "R5 hi drive width", oe_run, 4);
        oe_run = 0;
      end
      if (!aen_n) aen_run++;
      else if (aen_run != 0) begin
        chk(aen_run == 9, "R5 aen width", aen_run, 9);
        aen_run = 0;
      end
      if (!aen_n && aen_prev) begin
        chk(rom_hi_oe == 1'b0, "R5 no contention", rom_hi_oe, 0);
        acc_addr_q.push_back(int'({hi_q, rom_addr_lo}));
        acc_dir_q.push_back(dir_flag);
      end
    end
    aen_prev = aen_n;
    oe_prev = rom_hi_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] exp_q[$];
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R1 reset state while held
    chk(busy_n && aen_n && !dir_flag && !ale && !rom_hi_oe && !m_valid, "R1 reset held", {busy_n, aen_n, dir_flag, ale, rom_hi_oe, m_valid}, 6'b110000);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_n && aen_n && !dir_flag && !ale && !rom_hi_oe && !m_valid, "R1 after release", {busy_n, aen_n, dir_flag, ale, rom_hi_oe, m_valid}, 6'b110000);

    // R2 start with chip select high is ignored
    sel_n = 1'b1; msg_code = 8'h11; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy_n == 1'b1, "R2 sel_n high ignored", busy_n, 1);
    chk(acc_addr_q.size() == 0 && rom_hi_oe == 1'b0, "R2 no access when deselected", acc_addr_q.size(), 0);

    for (int k = 0; k < N_MSG; k++) begin
      logic [7:0] code;
      int s, a, nseg, got, guard;
      bit held;
      logic [7:0] held_v;
      code = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 19 + 3);
      s = (k == 1) ? 17'h1FDFA : 17'h01000 + k * 17'h01000 + 2 * int'($urandom % 512);
      rom[2 * code]     = s[8:1];
      rom[2 * code + 1] = {s[15:9], s[16]};
      exp_q.delete();
      a = s;
      nseg = 1 + int'($urandom % 3);
      for (int g = 0; g < nseg; g++) begin
        int len;
        len = 1 + int'($urandom % 4);
        rom[a] = 8'(len); exp_q.push_back(8'(len)); a = (a + 1) % 131072;
        for (int j = 0; j < len; j++) begin
          logic [7:0] v;
          v = (k == 2 && j == 0) ? 8'h00 : 8'($urandom);
          rom[a] = v; exp_q.push_back(v); a = (a + 1) % 131072;
        end
      end
      rom[a] = 8'h00;
      acc_addr_q.delete(); acc_dir_q.delete();

      sel_n = 1'b0; msg_code = code; start = 1'b1;
      @(negedge clk);
      start = 1'b0; msg_code = ~code;
      chk(busy_n == 1'b0, "R2 busy low after start", busy_n, 0);
      got = 0; guard = 0; held = 1'b0; held_v = 8'h00;
      while (busy_n == 1'b0 && guard < 12000) begin
        bit rdy;
        guard++;
        if (k == 4 && guard == 60) start = 1'b1;   // R3 ignored restart
        if (k == 4 && guard == 61) start = 1'b0;
        rdy = (k == 0) ? 1'b1 : (k == 3) ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
        m_ready = rdy;
        if (m_valid) begin
          if (held) chk(m_data == held_v, "R10 held byte stable", m_data, held_v);
          if (rdy) begin
            if (got < exp_q.size())
              chk(m_data == exp_q[got], "R9 R10 stream byte", m_data, exp_q[got]);
            else chk(1'b0, "R9 extra byte", got, exp_q.size());
            got++; held = 1'b0;
          end else begin
            chk(aen_n == 1'b1, "R10 no fetch while held", aen_n, 1);
            held = 1'b1; held_v = m_data;
          end
        end
        @(negedge clk);
      end
      m_ready = 1'b0;
      chk(got == exp_q.size(), "R9 byte count", got, exp_q.size());
      chk(acc_addr_q.size() == exp_q.size() + 3, "R9 access count", acc_addr_q.size(), exp_q.size() + 3);
      if (acc_addr_q.size() >= 3) begin
        int nd;
        nd = 0;
        foreach (acc_dir_q[i]) if (acc_dir_q[i]) nd++;
        chk(nd == 2 && acc_dir_q[0] && acc_dir_q[1], "R7 dir_flag on two reads", nd, 2);
        chk(acc_addr_q[0] == 2 * code, "R7 dir low addr", acc_addr_q[0], 2 * code);
        chk(acc_addr_q[1] == 2 * code + 1, "R7 dir high addr", acc_addr_q[1], 2 * code + 1);
        chk(acc_addr_q[2] == s, "R8 start address", acc_addr_q[2], s);
        for (int i = 3; i < acc_addr_q.size(); i++)
          if (acc_addr_q[i] != (s + i - 2) % 131072)
            chk(1'b0, "R4 R8 address sequence", acc_addr_q[i], (s + i - 2) % 131072);
      end
      repeat (8) @(negedge clk);
      chk(busy_n == 1'b1 && m_valid == 1'b0, "R3 R9 idle after end", busy_n, 1);
      sel_n = 1'b1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule